// File: doc/BRIEF.md
# Eight-Source Interrupt Controller Register Model

This block gathers up to eight device interrupt sources into a pending register and drives a single level-type request line toward the system chipset. Devices raise and clear pending bits through two bit-vector inputs that are sampled every clock. Software reaches the block through a small register bus. The bus carries an address, an access size code, and separate read and write strobes. Software can read the pending bits, program an enable mask, and retire individual sources by writing a source number.

The mask write is inverted on the way in. A written 1 masks a source and a written 0 unmasks it. The pending register can be read at byte width or as a zero-extended 64-bit word, because some software paths can only issue 64-bit loads.

A second, cascaded controller is present only as stub registers:
- its status reads as zero;
- its mask holds whatever is written;
- its acknowledge accepts writes and ignores them.

The request line is produced by a two-state machine:
- **QUIET**: the line is low.
- **RAISED**: the line is high.
- **raise** (QUIET to RAISED): taken when the next pending bits ANDed with the next enable bits are nonzero.
- **drop** (RAISED to QUIET): taken when that value becomes zero.

Top module: `intc_regs`

Register map (byte offsets on `bus_addr`):
- 0: primary status
- 1: primary mask
- 2: primary acknowledge
- 4: secondary status
- 5: secondary mask
- 6: secondary acknowledge

Size codes on `bus_size`:
- 0: 1 byte
- 1: 2 bytes
- 2: 4 bytes
- 3: 8 bytes

Read results appear on `rd_data` and `rd_err` in the cycle after the read strobe. Both are zero after a cycle with no read.

## Requirements
- R1: After reset the pending register is 0, the enable mask is 0 (every source masked, so a byte read of offset 1 returns 0xFF), and `irq_o` is low; raising a source while everything is masked keeps `irq_o` low.
- R2: A byte read (size 0) of offset 0 returns the pending bits in `rd_data[7:0]`, zeros above, and `rd_err` low, one cycle after the strobe.
- R3: An 8-byte read (size 3) of offset 0 returns the pending bits zero-extended to 64 bits with `rd_err` low.
- R4: A read with size 1 or 2 at any offset, or with size 3 at any offset other than 0, sets `rd_err` high for one cycle with `rd_data` zero.
- R5: A byte read of offset 4 returns 0x00 with `rd_err` low.
- R6: A byte write to offset 1 stores the complement of the written byte as the enable mask (written 1 masks source i, written 0 enables it); a byte read of offset 1 returns the byte last written.
- R7: `irq_o` is high exactly when the pending bits ANDed with the enable mask are nonzero, updated on the same clock edge as the registers (visible one cycle after the stimulus); it rises only because of a set input or a primary mask write.
- R8: A byte write to offset 2 clears pending bit number `bus_wdata[3:0]` (upper nibble ignored); a number from 8 to 15 leaves every pending bit unchanged.
- R9: `dev_set` ORs into the pending bits and `dev_clr` clears them; when both name the same bit in one cycle, or an acknowledge lands with a set, the clear wins.
- R10: A byte write to offset 5 stores the byte unmodified (read back at offset 5) and never affects `irq_o`; byte writes to offset 6 change nothing.
- R11: Writes with a size other than 0 are ignored; a byte read of any offset other than 0, 1, 4 and 5 returns 0x00 with `rd_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| dev_set | input | 8 | Per-source raise vector |
| dev_clr | input | 8 | Per-source clear vector |
| rd_data | output | 64 | Read result, one cycle after strobe |
| rd_err | output | 1 | Illegal read width/offset flag |
| irq_o | output | 1 | Level request to the chipset |

## Verification
The hardest situation to reach from the ports is the one where several updates to the pending bits meet on one edge. An example is an acknowledge, a set and a clear all aimed at the same source while the mask is partly open. Only then does the ordering of clear over set decide whether the request line falls.

Directed steps build these collisions deliberately, including acknowledge numbers 8 to 15 and upper-nibble garbage. A seeded random phase then mixes reads, writes of every size and dense set/clear vectors. A bench model predicts every read result and the line level each cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int REG_ADDR_W = 4;
    localparam int ACK_IDX_W  = 4;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_DWORD = 2'd3
    } acc_size_e;

    localparam logic [REG_ADDR_W-1:0] OFS_P_STAT = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFS_P_MASK = 4'h1;
    localparam logic [REG_ADDR_W-1:0] OFS_P_ACK  = 4'h2;
    localparam logic [REG_ADDR_W-1:0] OFS_S_STAT = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFS_S_MASK = 4'h5;
    localparam logic [REG_ADDR_W-1:0] OFS_S_ACK  = 4'h6;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/intc_mask.sv
// Byte-wide mask register; INVERT picks whether the written byte is stored
// complemented (primary) or verbatim (secondary stub).
module intc_mask #(
    parameter int NSRC   = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [7:0]      wdata,
    output logic [NSRC-1:0] mask_d,
    output logic [NSRC-1:0] mask_q,
    output logic [7:0]      raw_q
);
    logic [NSRC-1:0] stored;

    generate
        if (INVERT) begin : g_inv
            assign stored = ~wdata[NSRC-1:0];
            assign raw_q  = 8'(~mask_q) | ~8'((1 << NSRC) - 1);
        end else begin : g_plain
            assign stored = wdata[NSRC-1:0];
            assign raw_q  = 8'(mask_q);
        end
    endgenerate

    always_comb begin
        mask_d = we ? stored : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int NSRC = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSRC-1:0]                set_i,
    input  logic [NSRC-1:0]                clr_i,
    input  logic                           ack_we,
    input  logic [intc_pkg::ACK_IDX_W-1:0] ack_idx,
    output logic [NSRC-1:0]                pend_d,
    output logic [NSRC-1:0]                pend_q
);
    logic [NSRC-1:0] ack_vec;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            ack_vec[i] = ack_we && (int'(ack_idx) == i);
        end
        pend_d = (pend_q | set_i) & ~clr_i & ~ack_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R8
    ack_high_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && int'(ack_idx) >= NSRC && set_i == '0 && clr_i == '0)
        |=> pend_q == $past(pend_q));

    // R9
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~clr_i) && !ack_we)
        |=> (pend_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> (pend_q & $past(clr_i)) == '0);
endmodule

// File: rtl/intc_line_fsm.sv
module intc_line_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_d,
    output logic irq_o
);
    import intc_pkg::*;

    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (hit_d)  state_d = LINE_RAISED;
            LINE_RAISED: if (!hit_d) state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/intc_rd.sv
module intc_rd #(
    parameter int NSRC   = 8,
    parameter int DATA_W = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_i,
    input  logic [intc_pkg::REG_ADDR_W-1:0] addr_i,
    input  logic [1:0]                      size_i,
    input  logic [NSRC-1:0]                 pend_i,
    input  logic [7:0]                      p_raw_i,
    input  logic [7:0]                      s_raw_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic                            rd_err_o
);
    import intc_pkg::*;

    logic [DATA_W-1:0] data_d;
    logic              err_d;
    acc_size_e         sz;

    assign sz = acc_size_e'(size_i);

    always_comb begin
        data_d = '0;
        err_d  = 1'b0;
        if (rd_i) begin
            unique case (sz)
                ACC_BYTE: begin
                    if (addr_i == OFS_P_STAT)      data_d = DATA_W'(pend_i);
                    else if (addr_i == OFS_P_MASK) data_d = DATA_W'(p_raw_i);
                    else if (addr_i == OFS_S_MASK) data_d = DATA_W'(s_raw_i);
                end
                ACC_DWORD: begin
                    if (addr_i == OFS_P_STAT) data_d = DATA_W'(pend_i);
                    else                      err_d  = 1'b1;
                end
                ACC_HALF, ACC_WORD: err_d = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            rd_err_o  <= 1'b0;
        end else begin
            rd_data_o <= data_d;
            rd_err_o  <= err_d;
        end
    end

    // R4
    bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (size_i == 2'd1 || size_i == 2'd2)) |=> (rd_err_o && rd_data_o == '0));

    // R5
    sec_status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && size_i == 2'd0 && addr_i == OFS_S_STAT) |=> (rd_data_o == '0 && !rd_err_o));

    // R3
    dword_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && size_i == 2'd3 && addr_i == OFS_P_STAT)
        |=> (!rd_err_o && rd_data_o[DATA_W-1:NSRC] == '0));
endmodule

// File: rtl/intc_regs.sv
module intc_regs #(
    parameter int NSRC   = 8,
    parameter int DATA_W = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [intc_pkg::REG_ADDR_W-1:0] bus_addr,
    input  logic [1:0]                      bus_size,
    input  logic                            bus_rd,
    input  logic                            bus_wr,
    input  logic [7:0]                      bus_wdata,
    input  logic [NSRC-1:0]                 dev_set,
    input  logic [NSRC-1:0]                 dev_clr,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_err,
    output logic                            irq_o
);
    import intc_pkg::*;

    logic            wr_byte, p_mask_we, s_mask_we, p_ack_we;
    logic [NSRC-1:0] pend_d, pend_q, en_d, en_q, s_d, s_q;
    logic [7:0]      p_raw, s_raw;

    always_comb begin
        wr_byte   = bus_wr && (bus_size == 2'(ACC_BYTE));
        p_mask_we = wr_byte && (bus_addr == OFS_P_MASK);
        s_mask_we = wr_byte && (bus_addr == OFS_S_MASK);
        p_ack_we  = wr_byte && (bus_addr == OFS_P_ACK);
    end

    intc_mask #(.NSRC(NSRC), .INVERT(1'b1)) u_pmask (
        .clk(clk), .rst_n(rst_n), .we(p_mask_we), .wdata(bus_wdata),
        .mask_d(en_d), .mask_q(en_q), .raw_q(p_raw)
    );

    intc_mask #(.NSRC(NSRC), .INVERT(1'b0)) u_smask (
        .clk(clk), .rst_n(rst_n), .we(s_mask_we), .wdata(bus_wdata),
        .mask_d(s_d), .mask_q(s_q), .raw_q(s_raw)
    );

    intc_pending #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(dev_set), .clr_i(dev_clr),
        .ack_we(p_ack_we), .ack_idx(bus_wdata[ACK_IDX_W-1:0]),
        .pend_d(pend_d), .pend_q(pend_q)
    );

    intc_line_fsm u_line (
        .clk(clk), .rst_n(rst_n), .hit_d(|(pend_d & en_d)), .irq_o(irq_o)
    );

    intc_rd #(.NSRC(NSRC), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_i(bus_rd), .addr_i(bus_addr),
        .size_i(bus_size), .pend_i(pend_q), .p_raw_i(p_raw), .s_raw_i(s_raw),
        .rd_data_o(rd_data), .rd_err_o(rd_err)
    );

    // R7
    line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(pend_q & en_q));

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|dev_set || p_mask_we));

    // R10
    sec_mask_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_mask_we && dev_set == '0 && dev_clr == '0) |=> $stable(irq_o));

    // R10
    sec_mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_mask_we) |-> s_q == $past(s_q));

    // R6
    en_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_mask_we |=> $stable(en_q));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && !irq_o));

    logic unused_sd;
    assign unused_sd = ^s_d;
endmodule

// File: tb/intc_regs_test.sv
module intc_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  dev_set = '0;
    logic [7:0]  dev_clr = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_pend, m_praw, m_sraw;

    always #5 clk = ~clk;

    intc_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .dev_set(dev_set), .dev_clr(dev_clr),
        .rd_data(rd_data), .rd_err(rd_err), .irq_o(irq_o)
    );

    function automatic logic [64:0] exp_read(input logic [3:0] a, input logic [1:0] s);
        logic [64:0] r = '0;
        if (s == 2'd0) begin
            if (a == 4'h0)      r[63:0] = 64'(m_pend);
            else if (a == 4'h1) r[63:0] = 64'(m_praw);
            else if (a == 4'h5) r[63:0] = 64'(m_sraw);
        end else if (s == 2'd3 && a == 4'h0) begin
            r[63:0] = 64'(m_pend);
        end else begin
            r[64] = 1'b1;
        end
        return r;
    endfunction

    function automatic string read_tag(input logic [3:0] a, input logic [1:0] s);
        if (s == 2'd1 || s == 2'd2) return "R4";
        if (s == 2'd3) return (a == 4'h0) ? "R3" : "R4";
        if (a == 4'h0) return "R2";
        if (a == 4'h1) return "R6";
        if (a == 4'h4) return "R5";
        if (a == 4'h5) return "R10";
        return "R11";
    endfunction

    task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic [3:0] a,
                        input logic [1:0] s, input logic [7:0] wd,
                        input logic [7:0] st, input logic [7:0] cl, input string tag);
        logic [64:0] er;
        logic [7:0]  ackv;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = s;
        bus_wdata = wd; dev_set = st; dev_clr = cl;
        er = rd ? exp_read(a, s) : 65'd0;
        @(posedge clk);
        ackv = '0;
        if (wr && s == 2'd0) begin
            if (a == 4'h1) m_praw = wd;
            if (a == 4'h5) m_sraw = wd;
            if (a == 4'h2 && wd[3:0] < 4'd8) ackv = 8'(1 << wd[3:0]);
        end
        m_pend = (m_pend | st) & ~cl & ~ackv;
        @(negedge clk);
        chk({tag, " irq"}, 65'(irq_o), 65'(|(m_pend & ~m_praw)));
        if (rd) chk({tag, " read"}, {rd_err, rd_data}, er);
        else    chk({tag, " idle read"}, {rd_err, rd_data}, 65'd0);
    endtask

    task automatic rd_b(input logic [3:0] a, input logic [1:0] s, input string tag);
        step(1'b1, 1'b0, a, s, 8'h00, 8'h00, 8'h00, tag);
    endtask

    task automatic wr_b(input logic [3:0] a, input logic [1:0] s, input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, a, s, d, 8'h00, 8'h00, tag);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_1234);
        m_pend = '0; m_praw = 8'hFF; m_sraw = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq after reset", 65'(irq_o), 65'd0);
        rd_b(4'h0, 2'd0, "R1");
        rd_b(4'h1, 2'd0, "R1");
        step(1'b0, 1'b0, 4'h0, 2'd0, 8'h00, 8'h05, 8'h00, "R1 masked set");
        // R6 / R7: open bit 0
        wr_b(4'h1, 2'd0, 8'hFE, "R6");
        rd_b(4'h1, 2'd0, "R6");
        // R2 / R3
        rd_b(4'h0, 2'd0, "R2");
        rd_b(4'h0, 2'd3, "R3");
        // R4
        rd_b(4'h0, 2'd1, "R4");
        rd_b(4'h0, 2'd2, "R4");
        rd_b(4'h1, 2'd3, "R4");
        // R5
        rd_b(4'h4, 2'd0, "R5");
        // R10: secondary stub
        wr_b(4'h5, 2'd0, 8'h00, "R10");
        wr_b(4'h6, 2'd0, 8'h00, "R10");
        rd_b(4'h5, 2'd0, "R10");
        rd_b(4'h0, 2'd0, "R10");
        // R8: high index ignored, upper nibble ignored
        wr_b(4'h2, 2'd0, 8'h09, "R8");
        rd_b(4'h0, 2'd0, "R8");
        wr_b(4'h2, 2'd0, 8'hF0, "R8");
        rd_b(4'h0, 2'd0, "R8");
        // R9: clear wins over set
        wr_b(4'h1, 2'd0, 8'h00, "R6");
        step(1'b0, 1'b0, 4'h0, 2'd0, 8'h00, 8'h21, 8'h01, "R9");
        rd_b(4'h0, 2'd0, "R9");
        step(1'b0, 1'b1, 4'h2, 2'd0, 8'h03, 8'h08, 8'h00, "R9 ack with set");
        rd_b(4'h0, 2'd0, "R9");
        // R11: wide write ignored, unmapped byte read zero
        wr_b(4'h1, 2'd1, 8'hFF, "R11");
        rd_b(4'h1, 2'd0, "R11");
        rd_b(4'h3, 2'd0, "R11");
        rd_b(4'h7, 2'd0, "R11");
        // seeded random phase
        for (int k = 0; k < 600; k++) begin
            logic [3:0] a;
            logic [1:0] s;
            int op;
            a  = 4'($urandom % 8);
            s  = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
            op = int'($urandom % 3);
            if (op == 0) step(1'b1, 1'b0, a, s, 8'h00, 8'($urandom), 8'($urandom) & 8'($urandom), read_tag(a, s));
            else if (op == 1) step(1'b0, 1'b1, a, s, 8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom), "R7 random write");
            else step(1'b0, 1'b0, a, s, 8'h00, 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom), "R9 random device");
        end
        step(1'b0, 1'b0, 4'h0, 2'd0, 8'h00, 8'h00, 8'h00, "R7 idle");
        done = 1'b1;
        summary();
    end
endmodule